// File: doc/BRIEF.md
# Extended Register List Transfer Sequencer

This block moves a chosen subset of eight 80-bit floating-point registers between the register file and memory. Each register occupies a 12-byte memory image, and the block sends it as three 32-bit bus transfers. The first bus word carries the 16-bit sign/exponent field in its upper half and a 16-bit pad in its lower half. The second word holds mantissa bits 63:32 and the third holds mantissa bits 31:0. No value is converted: the 80-bit register content is copied as it stands.

A single `start` pulse presents the instruction extension word, the addressing mode and the base address. The register list comes either from the extension word or from the low byte of one of eight 32-bit integer data registers. The addressing mode fixes two things: how list bits map onto registers, and whether the block walks the registers upward or downward through memory.

The memory port is a valid/ready request channel. `mem_req` may only drop after a handshake. While `mem_req` is high and `mem_ready` is low, `mem_addr`, `mem_we` and `mem_wdata` hold their values. On a read, `mem_rdata` is taken in the cycle of the handshake. The register file is read combinationally and written with a one-cycle strobe. When the list is finished, or when the request is illegal, `done` pulses for one cycle and `final_addr` reports the updated address.

Top module: `fpx_list_xfer`

## Requirements
- R1: The list mode is `ext_word[12:11]` and the direction is `ext_word[13]` (1 = register to memory, 0 = memory to register). The list is dynamic when `ext_word[11]` is 1. A dynamic list is the low byte of data register `ext_word[6:4]` (register k is `dreg_bus[32k+31:32k]`). A static list is `ext_word[7:0]`.
- R2: The request is illegal in any of these cases: `amode` is 3; a memory-to-register transfer uses list mode 0 or 1; a memory-to-register transfer uses pre-decrement. An illegal request makes no memory or register-file access. It raises `done` and `invalid` together, in the cycle after `start`.
- R3: In control mode (`amode`=0) and post-increment mode (`amode`=1), list bit 7-i selects FPi. Registers are handled from FP0 up to FP7, and the k-th selected register's image sits at base+12k.
- R4: In pre-decrement mode (`amode`=2), list bit i selects FPi. Registers are handled from FP7 down to FP0, and the k-th selected register's image sits at base-12(k+1).
- R5: Each image is sent as three word transfers, at image offsets 0, 4 and 8 in that order. When storing, word 0 is {exp[15:0], 16'h0000}, word 1 is register bits 63:32 and word 2 is register bits 31:0.
- R6: When loading, the low 16 bits of word 0 are ignored. The register is written with {word0[31:16], word1, word2}, and the write strobe `rf_we` coincides with the handshake of word 2.
- R7: An empty list makes no memory access. It pulses `done` in the cycle after `start`, and `final_addr` equals the base address.
- R8: At `done`, `final_addr` equals base+12n in post-increment mode, base-12n in pre-decrement mode and base in control mode, where n is the number of selected registers.
- R9: While `mem_req` is high without `mem_ready`, the request stays up with `mem_addr`, `mem_we` and `mem_wdata` unchanged in the next cycle.
- R10: After reset `busy`, `done`, `mem_req` and `rf_we` are low. `busy` stays high from the cycle after `start` until `done`. `done` lasts exactly one cycle, and `start` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer (sampled when idle) |
| ext_word | input | 16 | Extension word: direction, list mode, data-register index, static list |
| amode | input | 2 | 0 control, 1 post-increment, 2 pre-decrement, 3 illegal |
| base_addr | input | 32 | Starting byte address |
| dreg_bus | input | 256 | Eight 32-bit integer data registers |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| invalid | output | 1 | Set with `done` for an illegal request |
| final_addr | output | 32 | Updated address, valid with `done` |
| mem_req | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts the request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Word byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid on a read handshake |
| rf_rd_idx | output | 3 | Register-file read index |
| rf_rd_data | input | 80 | Register-file read data |
| rf_we | output | 1 | Register-file write strobe |
| rf_wr_idx | output | 3 | Register-file write index |
| rf_wr_data | output | 80 | Register-file write data |

## Verification
The assertions rely on three things about the inputs: `mem_rdata` is meaningful only during a read handshake, `rf_rd_data` depends only on `rf_rd_idx`, and `start` is given only while the block is idle. The stimulus meets these assumptions. The memory model computes read data from the address alone. The register-file model is a fixed array for each operation. The bench raises `start` only after the previous `done` has been seen. `mem_ready` is driven randomly so that back-pressure stalls of several cycles occur.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  typedef enum logic [1:0] {
    AM_CTRL    = 2'd0,
    AM_POSTINC = 2'd1,
    AM_PREDEC  = 2'd2,
    AM_RSVD    = 2'd3
  } amode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_DONE = 2'd2
  } xfer_state_e;
endpackage

// File: rtl/fpx_list_resolve.sv
module fpx_list_resolve #(
  parameter int NREG  = 8,
  parameter int NDREG = 8,
  parameter int DW    = 32
) (
  input  logic [15:0]         ext_word,
  input  logic [1:0]          amode,
  input  logic [NDREG*DW-1:0] dreg_bus,
  output logic [NREG-1:0]     sel_mask,
  output logic                illegal
);
  import fpx_pkg::*;
  localparam int DIW = $clog2(NDREG);

  logic          store;
  logic [1:0]    lmode;
  logic [DIW-1:0] didx;
  logic [NREG-1:0] raw;
  logic          predec;

  assign store  = ext_word[13];
  assign lmode  = ext_word[12:11];
  assign didx   = ext_word[4 +: DIW];
  assign predec = (amode == AM_PREDEC);
  assign raw    = lmode[0] ? dreg_bus[didx*DW +: NREG] : ext_word[NREG-1:0];

  assign illegal = (amode == AM_RSVD) || (!store && (!lmode[1] || predec));

  for (genvar i = 0; i < NREG; i++) begin : g_map
    assign sel_mask[i] = predec ? raw[i] : raw[NREG-1-i];
  end
endmodule

// File: rtl/fpx_pick.sv
module fpx_pick #(
  parameter int NREG = 8,
  localparam int IW  = $clog2(NREG)
) (
  input  logic [NREG-1:0] mask,
  input  logic            descend,
  output logic [IW-1:0]   idx,
  output logic            any
);
  always_comb begin
    idx = '0;
    if (descend) begin
      for (int i = 0; i < NREG; i++)
        if (mask[i]) idx = IW'(i);
    end else begin
      for (int i = NREG - 1; i >= 0; i--)
        if (mask[i]) idx = IW'(i);
    end
  end
  assign any = |mask;
endmodule

// File: rtl/fpx_list_xfer.sv
module fpx_list_xfer #(
  parameter int NREG  = 8,
  parameter int NDREG = 8,
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int EXPW  = 16,
  parameter int MANW  = 64,
  localparam int RW   = EXPW + MANW,
  localparam int IW   = $clog2(NREG),
  localparam int IMG  = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [15:0]         ext_word,
  input  logic [1:0]          amode,
  input  logic [AW-1:0]       base_addr,
  input  logic [NDREG*DW-1:0] dreg_bus,
  output logic                busy,
  output logic                done,
  output logic                invalid,
  output logic [AW-1:0]       final_addr,
  output logic                mem_req,
  input  logic                mem_ready,
  output logic                mem_we,
  output logic [AW-1:0]       mem_addr,
  output logic [DW-1:0]       mem_wdata,
  input  logic [DW-1:0]       mem_rdata,
  output logic [IW-1:0]       rf_rd_idx,
  input  logic [RW-1:0]       rf_rd_data,
  output logic                rf_we,
  output logic [IW-1:0]       rf_wr_idx,
  output logic [RW-1:0]       rf_wr_data
);
  import fpx_pkg::*;

  xfer_state_e     state_q;
  logic [NREG-1:0] pend_q, new_mask, pend_next;
  logic [AW-1:0]   cursor_q, base_q, img_addr;
  logic [1:0]      am_q, word_q;
  logic            store_q, desc_q, inv_q, bad_req;
  logic [EXPW-1:0] exp_q;
  logic [DW-1:0]   hi_q;
  logic [IW-1:0]   cur;
  logic            pend_any, hs;

  fpx_list_resolve #(.NREG(NREG), .NDREG(NDREG), .DW(DW)) u_res (
    .ext_word(ext_word), .amode(amode), .dreg_bus(dreg_bus),
    .sel_mask(new_mask), .illegal(bad_req));

  fpx_pick #(.NREG(NREG)) u_pick (
    .mask(pend_q), .descend(desc_q), .idx(cur), .any(pend_any));

  assign hs        = mem_req && mem_ready;
  assign pend_next = pend_q & ~(NREG'(1) << cur);
  assign img_addr  = desc_q ? (cursor_q - AW'(IMG)) : cursor_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      pend_q   <= '0;
      cursor_q <= '0;
      base_q   <= '0;
      am_q     <= '0;
      word_q   <= '0;
      store_q  <= 1'b0;
      desc_q   <= 1'b0;
      inv_q    <= 1'b0;
      exp_q    <= '0;
      hi_q     <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start) begin
          base_q   <= base_addr;
          cursor_q <= base_addr;
          am_q     <= amode;
          store_q  <= ext_word[13];
          desc_q   <= (amode == AM_PREDEC);
          word_q   <= '0;
          inv_q    <= bad_req;
          pend_q   <= bad_req ? '0 : new_mask;
          state_q  <= (bad_req || new_mask == '0) ? ST_DONE : ST_XFER;
        end
        ST_XFER: if (hs) begin
          if (!store_q && word_q == 2'd0) exp_q <= mem_rdata[DW-1 -: EXPW];
          if (!store_q && word_q == 2'd1) hi_q  <= mem_rdata;
          if (word_q == 2'd2) begin
            word_q   <= '0;
            pend_q   <= pend_next;
            cursor_q <= desc_q ? (cursor_q - AW'(IMG)) : (cursor_q + AW'(IMG));
            if (pend_next == '0) state_q <= ST_DONE;
          end else begin
            word_q <= word_q + 2'd1;
          end
        end
        default: begin
          state_q <= ST_IDLE;
          inv_q   <= 1'b0;
        end
      endcase
    end
  end

  always_comb begin
    case (word_q)
      2'd0:    mem_wdata = {rf_rd_data[RW-1 -: EXPW], {(DW-EXPW){1'b0}}};
      2'd1:    mem_wdata = rf_rd_data[MANW-1 -: DW];
      default: mem_wdata = rf_rd_data[DW-1:0];
    endcase
  end

  assign mem_req    = (state_q == ST_XFER);
  assign mem_we     = store_q;
  assign mem_addr   = img_addr + {{(AW-4){1'b0}}, word_q, 2'b00};
  assign rf_rd_idx  = cur;
  assign rf_we      = hs && !store_q && (word_q == 2'd2);
  assign rf_wr_idx  = cur;
  assign rf_wr_data = {exp_q, hi_q, mem_rdata};
  assign busy       = (state_q != ST_IDLE);
  assign done       = (state_q == ST_DONE);
  assign invalid    = done && inv_q;
  assign final_addr = (am_q == AM_CTRL) ? base_q : cursor_q;

  AST_HOLD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R9
  AST_INVALID_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    invalid |-> done && !mem_req); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req && !rf_we); // R7
  AST_RFWE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> hs && !mem_we); // R6
  AST_PEND_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !$rose(mem_req) |-> $countones(pend_q) <= $countones($past(pend_q))); // R3
endmodule

// File: tb/sim_fpx_list_xfer.sv
`timescale 1ns/1ps
module sim_fpx_list_xfer;
  logic         clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [15:0]  ext_word = '0;
  logic [1:0]   amode = '0;
  logic [31:0]  base_addr = '0;
  logic [255:0] dreg_bus = '0;
  logic         busy, done, invalid, mem_req, mem_we, rf_we;
  logic         mem_ready = 1'b0;
  logic [31:0]  final_addr, mem_addr, mem_wdata, mem_rdata;
  logic [2:0]   rf_rd_idx, rf_wr_idx;
  logic [79:0]  rf_rd_data, rf_wr_data;
  logic [79:0]  fpr [8];

  always #2 clk = ~clk;

  fpx_list_xfer u0 (.*);

  function automatic logic [31:0] rdfn(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h5A5A0F0F;
  endfunction
  assign mem_rdata  = rdfn(mem_addr);
  assign rf_rd_data = fpr[rf_rd_idx];

  int checks = 0, errors = 0;
  logic [31:0] ex_addr [24];
  logic        ex_we   [24];
  logic [31:0] ex_data [24];
  logic [2:0]  ex_ri   [8];
  logic [79:0] ex_rd   [8];
  int ex_n = 0, hs_n = 0, rf_exp = 0, rf_n = 0;
  logic prev_stall = 1'b0;
  logic [31:0] prev_addr, prev_data;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // memory-side monitor: drives ready and checks each handshake
  initial begin
    forever begin
      @(negedge clk);
      mem_ready = ($urandom % 3) != 0;
      #1;
      if (rst_n) begin
        if (prev_stall)
          chk(mem_req && mem_addr == prev_addr && mem_wdata == prev_data, "R9 hold",
              {mem_req, mem_addr}, {1'b1, prev_addr});
        prev_stall = mem_req && !mem_ready;
        prev_addr  = mem_addr;
        prev_data  = mem_wdata;
        if (mem_req && mem_ready) begin
          if (hs_n < ex_n) begin
            chk(mem_addr == ex_addr[hs_n] && mem_we == ex_we[hs_n], "R3/R4/R5 addr",
                {mem_we, mem_addr}, {ex_we[hs_n], ex_addr[hs_n]});
            if (ex_we[hs_n])
              chk(mem_wdata == ex_data[hs_n], "R5 wdata", mem_wdata, ex_data[hs_n]);
          end
          hs_n++;
        end
        if (rf_we) begin
          if (rf_n < rf_exp)
            chk(rf_wr_idx == ex_ri[rf_n] && rf_wr_data == ex_rd[rf_n], "R6 rf write",
                {rf_wr_idx, rf_wr_data}, {ex_ri[rf_n], ex_rd[rf_n]});
          rf_n++;
        end
      end
    end
  end

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        finish_run();
      end
    end
  end

  task automatic run_op(input logic [15:0] ew, input logic [1:0] am, input logic [31:0] base);
    logic store, illegal;
    logic [7:0] raw, sel;
    logic [31:0] img, fin;
    int n = 0, waitc = 0;
    store = ew[13];
    illegal = (am == 2'd3) || (!store && (ew[12:11] < 2 || am == 2'd2));
    raw = ew[11] ? dreg_bus[ew[6:4]*32 +: 8] : ew[7:0];
    for (int i = 0; i < 8; i++) sel[i] = (am == 2'd2) ? raw[i] : raw[7-i];
    @(negedge clk);
    ex_n = 0; hs_n = 0; rf_exp = 0; rf_n = 0;
    if (!illegal) begin
      for (int k = 0; k < 8; k++) begin
        int r = (am == 2'd2) ? 7 - k : k;
        if (sel[r]) begin
          img = (am == 2'd2) ? base - 32'(12 * (n + 1)) : base + 32'(12 * n);
          for (int w = 0; w < 3; w++) begin
            ex_addr[ex_n] = img + 32'(4 * w);
            ex_we[ex_n]   = store;
            ex_data[ex_n] = (w == 0) ? {fpr[r][79:64], 16'h0} : (w == 1) ? fpr[r][63:32] : fpr[r][31:0];
            ex_n++;
          end
          if (!store) begin
            ex_ri[rf_exp] = 3'(r);
            ex_rd[rf_exp] = {rdfn(img)[31:16], rdfn(img + 4), rdfn(img + 8)};
            rf_exp++;
          end
          n++;
        end
      end
    end
    fin = (am == 2'd1) ? base + 32'(12 * n) : (am == 2'd2) ? base - 32'(12 * n) : base;
    ext_word = ew; amode = am; base_addr = base; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    #1;
    while (!done && waitc < 400) begin
      chk(busy, "R10 busy", busy, 1);
      @(negedge clk); #1; waitc++;
    end
    chk(done, "R10 done seen", done, 1);
    chk(invalid == illegal, "R2 invalid", invalid, illegal);
    if (illegal || n == 0) chk(waitc == 0, "R2/R7 done timing", waitc, 0);
    if (!illegal) chk(final_addr == fin, "R8 final_addr", final_addr, fin);
    chk(hs_n == ex_n, "R7 access count", hs_n, ex_n);
    chk(rf_n == rf_exp, "R6 rf write count", rf_n, rf_exp);
    @(negedge clk); #1;
    chk(!done && !busy, "R10 done one cycle", {done, busy}, 0);
  endtask

  task automatic new_data();
    for (int i = 0; i < 8; i++) fpr[i] = {$urandom, $urandom, $urandom};
    for (int i = 0; i < 8; i++) dreg_bus[i*32 +: 32] = $urandom;
  endtask

  initial begin
    void'($urandom(32'd2024));
    new_data();
    repeat (3) @(negedge clk);
    #1;
    chk(!busy && !done && !mem_req && !rf_we, "R10 reset", {busy, done, mem_req, rf_we}, 0);
    rst_n = 1'b1;
    // directed corners
    run_op(16'h2080, 2'd0, 32'h1000);            // R3 store control, bit7 -> FP0
    run_op(16'h2080, 2'd2, 32'h2000);            // R4 store predec, bit7 -> FP7
    run_op(16'h20FF, 2'd2, 32'h3000);            // R4 full predec
    run_op(16'h10FF, 2'd1, 32'h4000);            // R6 full load postinc
    run_op(16'h1000, 2'd1, 32'h5000);            // R7 empty list
    run_op(16'h0081, 2'd1, 32'h6000);            // R2 load mode 0
    run_op(16'h1081, 2'd2, 32'h7000);            // R2 load predec
    run_op(16'h2081, 2'd3, 32'h8000);            // R2 amode 3
    dreg_bus[3*32 +: 32] = 32'hFFFF_FF41;
    run_op(16'h2830, 2'd0, 32'h9000);            // R1 dynamic store, D3 low byte
    run_op(16'h1830, 2'd1, 32'hA000);            // R1 dynamic load mode 3
    for (int t = 0; t < 300; t++) begin
      logic [15:0] ew;
      new_data();
      ew = 16'($urandom);
      ew[15:14] = 2'b11;
      if ($urandom % 8 == 0) ew[7:0] = 8'h00;
      run_op(ew, 2'($urandom), $urandom & 32'hFFFF_FFFC);
    end
    finish_run();
  end
endmodule